// File: doc/BRIEF.md
# Flash Erase Status Bit Generator

This block is the device-side status logic of a NOR-style flash model. While an embedded erase is running or suspended, it produces the three erase status bits that a host polls on the data bus. The command decoder feeds it single-cycle events: sector-erase confirm with a sector index, chip-erase start, suspend, resume and erase done. The host side feeds it read strobes and the sector that each read addresses.

The block splits the erase information across its bits. `dq6_toggle` inverts on every read while the erase is running and freezes during a suspend. It does not depend on the address. `dq2_toggle` inverts only on reads that address a sector marked for erase, and it does so whether the erase is running or suspended. `dq3_timer` flags that a sector erase has begun. `status_drive` tells the data-bus mux whether a read returns status or array data. A host that polls both toggle bits can tell where a sector stands and what mode the erase is in.

All event inputs are sampled on the rising clock edge. A new mode takes effect from the next cycle. So a read in the same cycle as a command is handled under the old mode, and toggling becomes valid only after the command cycle has been registered.

Top module: `erase_status_gen`

## Requirements
- R1: After reset, `dq3_timer`, `dq2_toggle` and `dq6_toggle` are 0, the block is idle, no sector is marked, and `status_drive` is 0 for any read.
- R2: A `sec_erase_confirm` pulse while idle makes the block active from the next cycle. From then on `dq3_timer` reads 1 and only sector `confirm_sector` is marked for erase.
- R3: A `chip_erase_start` pulse while idle makes the block active with every sector marked, and `dq3_timer` stays 0. If both start events arrive in the same idle cycle, the sector erase wins.
- R4: While active, each cycle in which `rd_oe` or `rd_ce` is high counts as exactly one read. Each such read inverts `dq6_toggle` at the next edge, whatever sector it addresses. Both strobes high in one cycle count as one read.
- R5: While active or suspended, a read whose `rd_sector` is marked inverts `dq2_toggle` at the next edge. A read to an unmarked sector leaves `dq2_toggle` unchanged.
- R6: An `erase_suspend` pulse while active enters the suspended mode. There, reads leave `dq6_toggle` unchanged. An `erase_resume` pulse while suspended returns to active, and `dq6_toggle` toggles again.
- R7: `status_drive` depends on the current mode and `rd_sector`. It is 1 for any sector while active, 1 only for marked sectors while suspended, and 0 while idle.
- R8: An `erase_done` pulse while active or suspended returns the block to idle at the next edge. All three status bits clear and every mark is removed. Done takes priority over suspend or resume in the same cycle.
- R9: Events that arrive in the wrong mode are ignored. These are a start event while active or suspended, suspend while idle or suspended, resume while idle or active, and done while idle. The status bits and the marks stay as they were.
- R10: A read in the same cycle as a start, suspend or resume event is handled under the mode in force before that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_erase_confirm | input | 1 | Sector-erase confirm event, one cycle |
| confirm_sector | input | SEC_W | Sector index that goes with the confirm |
| chip_erase_start | input | 1 | Chip-erase start event, one cycle |
| erase_suspend | input | 1 | Suspend event |
| erase_resume | input | 1 | Resume event |
| erase_done | input | 1 | Erase completion event |
| rd_oe | input | 1 | Read strobe via output enable |
| rd_ce | input | 1 | Read strobe via chip enable |
| rd_sector | input | SEC_W | Sector addressed by the current read |
| dq3_timer | output | 1 | Sector-erase started flag |
| dq2_toggle | output | 1 | Per-sector erase toggle bit |
| dq6_toggle | output | 1 | Erase-active toggle bit |
| status_drive | output | 1 | 1 when the read returns status instead of array data |

## Verification
A wrong mode register shows up at once on `status_drive`. It also shows on the first read after the fault, because `dq6_toggle` either freezes when it should toggle or toggles when it should freeze. A corrupted sector mark stays invisible until a read addresses that sector. At that point `dq2_toggle` and, during a suspend, `status_drive` give the wrong value on that very read. A `dq3_timer` or toggle bit that is not cleared on done appears in the first cycle after completion.

// File: rtl/esg_pkg.sv
package esg_pkg;
    typedef enum logic [1:0] {
        ES_IDLE   = 2'd0,
        ES_ACTIVE = 2'd1,
        ES_SUSP   = 2'd2
    } erase_mode_e;

    typedef struct packed {
        erase_mode_e mode;
        logic        timer;
    } mode_regs_t;

    typedef struct packed {
        logic dq2;
        logic dq6;
    } toggle_regs_t;
endpackage

// File: rtl/esg_mode_fsm.sv
module esg_mode_fsm
    import esg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_start,
    input  logic        chip_start,
    input  logic        suspend,
    input  logic        resume,
    input  logic        done,
    output erase_mode_e mode_o,
    output logic        timer_o,
    output logic        load_one_o,
    output logic        load_all_o,
    output logic        clear_o
);
    mode_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        load_one_o = 1'b0;
        load_all_o = 1'b0;
        clear_o    = 1'b0;
        unique case (r_q.mode)
            ES_IDLE: begin
                if (sec_start) begin
                    r_d.mode   = ES_ACTIVE;
                    r_d.timer  = 1'b1;
                    load_one_o = 1'b1;
                end else if (chip_start) begin
                    r_d.mode   = ES_ACTIVE;
                    load_all_o = 1'b1;
                end
            end
            ES_ACTIVE: begin
                if (done) begin
                    r_d     = '{mode: ES_IDLE, timer: 1'b0};
                    clear_o = 1'b1;
                end else if (suspend) begin
                    r_d.mode = ES_SUSP;
                end
            end
            ES_SUSP: begin
                if (done) begin
                    r_d     = '{mode: ES_IDLE, timer: 1'b0};
                    clear_o = 1'b1;
                end else if (resume) begin
                    r_d.mode = ES_ACTIVE;
                end
            end
            default: r_d = '{mode: ES_IDLE, timer: 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{mode: ES_IDLE, timer: 1'b0};
        else        r_q <= r_d;
    end

    assign mode_o  = r_q.mode;
    assign timer_o = r_q.timer;
endmodule

// File: rtl/esg_sector_mask.sv
module esg_sector_mask #(
    parameter int NUM_SECTORS = 8,
    localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_one,
    input  logic                   load_all,
    input  logic                   clear,
    input  logic [SEC_W-1:0]       load_sector,
    output logic [NUM_SECTORS-1:0] mask_o
);
    logic [NUM_SECTORS-1:0] mask_d, mask_q;

    for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
        always_comb begin
            mask_d[i] = mask_q[i];
            if (clear)                                            mask_d[i] = 1'b0;
            else if (load_all)                                    mask_d[i] = 1'b1;
            else if (load_one && (load_sector == SEC_W'(i)))      mask_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/esg_toggle_pair.sv
module esg_toggle_pair
    import esg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  erase_mode_e mode,
    input  logic        rd,
    input  logic        sel_hit,
    input  logic        clear,
    output logic        dq2_o,
    output logic        dq6_o
);
    toggle_regs_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clear) begin
            t_d = '0;
        end else if (rd) begin
            if (mode == ES_ACTIVE)                t_d.dq6 = ~t_q.dq6;
            if ((mode != ES_IDLE) && sel_hit)     t_d.dq2 = ~t_q.dq2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign dq2_o = t_q.dq2;
    assign dq6_o = t_q.dq6;
endmodule

// File: rtl/erase_status_gen.sv
module erase_status_gen
    import esg_pkg::*;
#(
    parameter int NUM_SECTORS = 8,
    localparam int SEC_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_erase_confirm,
    input  logic [SEC_W-1:0] confirm_sector,
    input  logic             chip_erase_start,
    input  logic             erase_suspend,
    input  logic             erase_resume,
    input  logic             erase_done,
    input  logic             rd_oe,
    input  logic             rd_ce,
    input  logic [SEC_W-1:0] rd_sector,
    output logic             dq3_timer,
    output logic             dq2_toggle,
    output logic             dq6_toggle,
    output logic             status_drive
);
    erase_mode_e            mode_q;
    logic [NUM_SECTORS-1:0] mask_q;
    logic                   load_one, load_all, clear_all;
    logic                   rd_any, sel_hit;

    assign rd_any  = rd_oe | rd_ce;
    assign sel_hit = mask_q[rd_sector];

    esg_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sec_start  (sec_erase_confirm),
        .chip_start (chip_erase_start),
        .suspend    (erase_suspend),
        .resume     (erase_resume),
        .done       (erase_done),
        .mode_o     (mode_q),
        .timer_o    (dq3_timer),
        .load_one_o (load_one),
        .load_all_o (load_all),
        .clear_o    (clear_all)
    );

    esg_sector_mask #(.NUM_SECTORS(NUM_SECTORS)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_one    (load_one),
        .load_all    (load_all),
        .clear       (clear_all),
        .load_sector (confirm_sector),
        .mask_o      (mask_q)
    );

    esg_toggle_pair u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .rd      (rd_any),
        .sel_hit (sel_hit),
        .clear   (clear_all),
        .dq2_o   (dq2_toggle),
        .dq6_o   (dq6_toggle)
    );

    always_comb begin
        unique case (mode_q)
            ES_ACTIVE: status_drive = 1'b1;
            ES_SUSP:   status_drive = sel_hit;
            default:   status_drive = 1'b0;
        endcase
    end
endmodule

// File: rtl/esg_checker.sv
module esg_checker
    import esg_pkg::*;
#(
    parameter int NUM_SECTORS = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sec_erase_confirm,
    input logic                   chip_erase_start,
    input logic                   erase_done,
    input logic                   rd_any,
    input logic                   sel_hit,
    input erase_mode_e            mode_q,
    input logic [NUM_SECTORS-1:0] mask_q,
    input logic                   dq2_toggle,
    input logic                   dq3_timer,
    input logic                   dq6_toggle
);
    // R2: a sector confirm in idle raises the timer flag and marks one sector
    assert_sector_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ES_IDLE && sec_erase_confirm) |=> (dq3_timer && $countones(mask_q) == 1));

    // R3: a chip erase alone keeps the timer flag low
    assert_chip_no_timer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ES_IDLE && chip_erase_start && !sec_erase_confirm) |=> !dq3_timer);

    // R4: an active read flips dq6
    assert_dq6_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ES_ACTIVE && rd_any && !erase_done) |=> (dq6_toggle != $past(dq6_toggle)));

    // R5: a read to an unmarked sector leaves dq2 alone
    assert_dq2_unsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_any && !sel_hit && !erase_done) |=> $stable(dq2_toggle));

    // R6: dq6 is frozen while suspended
    assert_dq6_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ES_SUSP && !erase_done) |=> $stable(dq6_toggle));

    // R8: completion clears everything
    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != ES_IDLE && erase_done) |=>
            (!dq3_timer && !dq2_toggle && !dq6_toggle && mask_q == '0 && mode_q == ES_IDLE));
endmodule

bind erase_status_gen esg_checker #(.NUM_SECTORS(NUM_SECTORS)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .sec_erase_confirm (sec_erase_confirm),
    .chip_erase_start  (chip_erase_start),
    .erase_done        (erase_done),
    .rd_any            (rd_any),
    .sel_hit           (sel_hit),
    .mode_q            (mode_q),
    .mask_q            (mask_q),
    .dq2_toggle        (dq2_toggle),
    .dq3_timer         (dq3_timer),
    .dq6_toggle        (dq6_toggle)
);

// File: tb/erase_status_gen_tb.sv
`timescale 1ns/1ps
module erase_status_gen_tb;
    localparam int NS = 8;
    localparam int SW = 3;

    typedef struct {
        logic  d3, d2, d6;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conf = 0, chip = 0, susp = 0, res = 0, done = 0, oe = 0, ce = 0;
    logic [SW-1:0] csec = '0, rsec = '0;
    logic dq3, dq2, dq6, drv;

    int errors = 0;
    int checks = 0;
    bit finished = 0;
    exp_t q[$];

    // bench model
    int          mst = 0;
    logic [NS-1:0] mmask = '0;
    logic        m3 = 0, m2 = 0, m6 = 0;

    always #2 clk = ~clk;

    erase_status_gen #(.NUM_SECTORS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .sec_erase_confirm(conf), .confirm_sector(csec),
        .chip_erase_start(chip), .erase_suspend(susp),
        .erase_resume(res), .erase_done(done),
        .rd_oe(oe), .rd_ce(ce), .rd_sector(rsec),
        .dq3_timer(dq3), .dq2_toggle(dq2), .dq6_toggle(dq6),
        .status_drive(drv)
    );

    task automatic step(input logic c, input int cs, input logic ch,
                        input logic s, input logic r, input logic d,
                        input logic o, input logic e, input int rs,
                        input string req);
        logic rd, edrv;
        exp_t it;
        @(negedge clk);
        conf = c; csec = SW'(cs); chip = ch; susp = s; res = r;
        done = d; oe = o; ce = e; rsec = SW'(rs);
        rd   = o | e;
        edrv = (mst == 1) ? 1'b1 : (mst == 2) ? mmask[rs] : 1'b0;
        #1;
        checks++;
        if (drv !== edrv) begin
            errors++;
            $display("FAIL %s status_drive actual=%b expected=%b", req, drv, edrv);
        end
        if (mst != 0 && d) begin
            mst = 0; mmask = '0; m3 = 0; m2 = 0; m6 = 0;
        end else begin
            if (rd && mst == 1) m6 = ~m6;
            if (rd && mst != 0 && mmask[rs]) m2 = ~m2;
            case (mst)
                0: if (c) begin mst = 1; mmask = NS'(1) << cs; m3 = 1; end
                   else if (ch) begin mst = 1; mmask = '1; end
                1: if (s) mst = 2;
                2: if (r) mst = 1;
                default: ;
            endcase
        end
        it.d3 = m3; it.d2 = m2; it.d6 = m6; it.req = req;
        q.push_back(it);
    endtask

    task automatic rd_step(input logic o, input logic e, input int rs, input string req);
        step(0, 0, 0, 0, 0, 0, o, e, rs, req);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                checks++;
                if (dq3 !== it.d3 || dq2 !== it.d2 || dq6 !== it.d6) begin
                    errors++;
                    $display("FAIL %s {dq3,dq2,dq6} actual=%b%b%b expected=%b%b%b",
                             it.req, dq3, dq2, dq6, it.d3, it.d2, it.d6);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state and idle reads
        rd_step(1, 0, 2, "R1");
        rd_step(0, 1, 7, "R1");
        // R9: suspend, resume and done while idle are ignored
        step(0, 0, 0, 1, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 0, 1, 1, 1, 0, 0, "R9");
        // R2 + R10: confirm sector 3 with a read in the same cycle
        step(1, 3, 0, 0, 0, 0, 1, 0, 3, "R10");
        // R4 + R5: reads to the marked sector, each strobe, both
        rd_step(1, 0, 3, "R5");
        rd_step(0, 1, 3, "R4");
        rd_step(1, 1, 3, "R4");
        rd_step(0, 0, 3, "R2");
        // R5: unmarked sector, dq6 only
        rd_step(1, 0, 5, "R5");
        rd_step(0, 1, 0, "R4");
        // R9: second confirm and chip start while active are ignored
        step(1, 5, 0, 0, 0, 0, 0, 0, 5, "R9");
        step(0, 0, 1, 0, 1, 0, 0, 0, 5, "R9");
        rd_step(1, 0, 5, "R9");
        // R6 + R10: suspend with a read in the same cycle
        step(0, 0, 0, 1, 0, 0, 1, 0, 3, "R10");
        rd_step(1, 0, 3, "R6");
        rd_step(0, 1, 3, "R7");
        rd_step(1, 0, 5, "R7");
        step(0, 0, 0, 1, 0, 0, 1, 0, 6, "R9");
        // resume
        step(0, 0, 0, 0, 1, 0, 0, 0, 5, "R6");
        rd_step(1, 0, 5, "R6");
        rd_step(1, 0, 3, "R6");
        // R8: done beats suspend in the same cycle
        step(0, 0, 0, 1, 0, 1, 1, 0, 3, "R8");
        rd_step(1, 0, 3, "R8");
        // R3: chip erase, and both starts together picks the sector erase
        step(0, 0, 1, 0, 0, 0, 0, 0, 0, "R3");
        rd_step(1, 0, 0, "R3");
        rd_step(0, 1, 7, "R3");
        step(0, 0, 0, 1, 0, 0, 0, 0, 4, "R7");
        rd_step(1, 0, 4, "R7");
        rd_step(0, 1, 1, "R6");
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
        step(1, 6, 1, 0, 0, 0, 0, 0, 0, "R3");
        rd_step(1, 0, 6, "R3");
        rd_step(1, 0, 2, "R3");
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
        rd_step(1, 1, 6, "R8");
        @(negedge clk);
        oe = 0; ce = 0;
        @(posedge clk); #2;
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule